// File: doc/BRIEF.md
# Strobe-Captured Parallel-to-Serial Framer

This block takes parallel words that arrive on the rising edge of a strobe clock. The strobe clock may be asynchronous to the block's own clock. Each word is packed into a fixed 14-slot serial frame and sent on a source-synchronous pair: a bit clock and a serial data line. The serial data changes on both halves of the bit clock, so a frame takes seven bit-clock periods. The bit-clock source is modelled as a `bit_en` pulse train in the `clk` domain. A 2-bit selector stretches every serial slot over one, two or three of those pulses, which has the same effect as dividing the reference first.

A captured word crosses into the `clk` domain through a toggle handshake and waits in a one-deep holding register until the next frame boundary. If no word is waiting when a frame opens, an all-zero filler frame is sent. The strobe must therefore run no faster than the frame rate. If a second word arrives while one is still held, the newer word replaces it and an overrun pulse is raised. Serialization runs only while the transmit-direction input is high, the clock-lock input is high and the selector is non-zero.

Top module: `strobe_serial_framer`

## Requirements
- R1: A frame is 14 serial slots, and each slot lasts exactly `div` pulses of `bit_en`. `ser_clk` is high during even slots and low during odd slots, so a frame is seven `ser_clk` periods. After activation, the first slot begins on the `div`-th `bit_en` pulse.
- R2: A data frame is sent MSB first. The first slot is the valid flag (1), the second slot is the start marker, and the 12-bit payload follows MSB first.
- R3: The start marker is 1 on a data frame that follows a filler frame or activation. It is 0 on a data frame that follows another data frame.
- R4: When no word is held at a frame boundary, all 14 slots of that frame are 0.
- R5: Every rising `stb_clk` edge outside strobe reset captures `pdata`. When the strobe is no faster than the frame rate, each captured word is sent exactly once and in order.
- R6: When the strobe period equals the frame period, no filler frame appears between the first and the last data frame of a burst.
- R7: `ref_div_sel` encodings: 01 gives `div`=1, 10 gives `div`=2, 11 gives `div`=3, and 00 stops the serializer.
- R8: While `tx_dir` is low, `clk_locked` is low or `ref_div_sel` is 00, `ser_clk` and `ser_dat` stay at 0. Words strobed during that time are never sent.
- R9: A word that arrives while an earlier word is still held raises `overrun` for one cycle and replaces the held word. No overrun occurs when the strobe is slower than the frame rate.
- R10: After reset, `ser_clk`, `ser_dat` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bit-clock enable is in this domain |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| stb_clk | input | 1 | Strobe; its rising edge captures a word |
| stb_rst | input | 1 | Synchronous active-high reset, strobe domain |
| pdata | input | PAY_W | Parallel word, sampled on the strobe's rising edge |
| tx_dir | input | 1 | High selects transmit operation |
| clk_locked | input | 1 | High when the bit-clock source is stable |
| ref_div_sel | input | 2 | Slot stretch select: 01 /1, 10 /2, 11 /3, 00 off |
| bit_en | input | 1 | One pulse per half bit-clock period from the clock source |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data, one bit per `ser_clk` half period |
| overrun | output | 1 | One-cycle pulse when a held word is replaced |

## Verification
The bench runs its own slot timer and decodes each frame from the pins. It targets these corner cases:
- Strobe exactly at the frame rate. A design that misaligns hand-over and load would insert filler frames or repeat words.
- A strobe three times faster than the frame. A design that kept the oldest word, or missed the overrun, would end on the wrong final word or show no pulse.
- The start marker across filler and back-to-back data. A design that tracked the marker wrongly would flag the wrong frames.
- The three inactive conditions, with words strobed during each. A design that kept those words would send them after reactivation.
- Slot stretching by two and by three with a sparse enable. A wrong prescaler shows up as `ser_clk` edges in the wrong cycle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    SFR_OFF  = 2'b00,
    SFR_DIV1 = 2'b01,
    SFR_DIV2 = 2'b10,
    SFR_DIV3 = 2'b11
  } sfr_mode_e;

  // Number of bit_en pulses that make up one serial slot.
  function automatic logic [1:0] sfr_div(input logic [1:0] sel);
    case (sel)
      SFR_DIV2: return 2'd2;
      SFR_DIV3: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/sfr_strobe_capture.sv
module sfr_strobe_capture #(
  parameter int PAY_W = 12
) (
  input  logic             stb_clk,
  input  logic             stb_rst,
  input  logic [PAY_W-1:0] pdata,
  output logic [PAY_W-1:0] cap_word,
  output logic             cap_tog
);

  always_ff @(posedge stb_clk) begin
    if (stb_rst) begin
      cap_word <= '0;
      cap_tog  <= 1'b0;
    end else begin
      cap_word <= pdata;
      cap_tog  <= ~cap_tog;
    end
  end

  AST_TOGGLE_PER_STROBE: assert property (@(posedge stb_clk) disable iff (stb_rst)
    !$past(stb_rst) |-> cap_tog != $past(cap_tog)); // R5

endmodule

// File: rtl/sfr_word_handoff.sv
module sfr_word_handoff #(
  parameter int PAY_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             take,
  input  logic             tog_in,
  input  logic [PAY_W-1:0] word_in,
  output logic             hold_vld,
  output logic [PAY_W-1:0] hold_word,
  output logic             ovf
);

  // SYNC_STAGES synchronizer flops plus one flop for edge detection.
  logic [SYNC_STAGES:0] sync_q;
  logic                 evt;

  assign evt = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      hold_vld  <= 1'b0;
      hold_word <= '0;
      ovf       <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], tog_in};
      if (!active) begin
        hold_vld <= 1'b0;
        ovf      <= 1'b0;
      end else if (evt) begin
        hold_word <= word_in;
        hold_vld  <= 1'b1;
        ovf       <= hold_vld && !take;
      end else begin
        ovf <= 1'b0;
        if (take) hold_vld <= 1'b0;
      end
    end
  end

  AST_OVF_NEEDS_HELD_WORD: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(hold_vld)); // R9
  AST_TAKE_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && take && !evt) |=> !hold_vld); // R5
  AST_IDLE_DROPS_WORD: assert property (@(posedge clk) disable iff (rst)
    !active |=> !hold_vld); // R8

endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer #(
  parameter int FRAME_W = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       bit_en,
  input  logic [1:0] div,
  output logic       step,
  output logic       load
);

  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic [1:0]       pre_cnt;
  logic [IDX_W-1:0] slot;
  logic             pre_end;

  assign pre_end = (pre_cnt == div - 2'd1);
  assign step    = active && bit_en && pre_end;
  assign load    = step && (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pre_cnt <= '0;
      slot    <= LAST;
    end else if (bit_en) begin
      if (pre_end) begin
        pre_cnt <= '0;
        slot    <= (slot == LAST) ? '0 : slot + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 2'd1;
      end
    end
  end

  AST_PRESCALE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> pre_cnt < div); // R7
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST); // R1

endmodule

// File: rtl/sfr_frame_shifter.sv
module sfr_frame_shifter #(
  parameter int PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             step,
  input  logic             load,
  input  logic             hold_vld,
  input  logic [PAY_W-1:0] hold_word,
  output logic             ser_clk,
  output logic             ser_dat
);

  localparam int FRAME_W = PAY_W + 2;

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_next;
  logic               after_fill;

  assign frame_next = hold_vld ? {1'b1, after_fill, hold_word} : '0;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      shreg      <= '0;
      ser_clk    <= 1'b0;
      ser_dat    <= 1'b0;
      after_fill <= 1'b1;
    end else if (step) begin
      if (load) begin
        ser_dat    <= frame_next[FRAME_W-1];
        shreg      <= {frame_next[FRAME_W-2:0], 1'b0};
        ser_clk    <= 1'b1;
        after_fill <= !hold_vld;
      end else begin
        ser_dat <= shreg[FRAME_W-1];
        shreg   <= {shreg[FRAME_W-2:0], 1'b0};
        ser_clk <= ~ser_clk;
      end
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!ser_clk && !ser_dat)); // R8
  AST_FRAME_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    load |=> ser_clk); // R1
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (rst)
    (active && !step) |=> ($stable(ser_clk) && $stable(ser_dat))); // R1
  AST_FILLER_LEADS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (load && !hold_vld) |=> !ser_dat); // R4
  AST_DATA_LEADS_ONE: assert property (@(posedge clk) disable iff (rst)
    (load && hold_vld) |=> ser_dat); // R2

endmodule

// File: rtl/strobe_serial_framer.sv
module strobe_serial_framer
  import sfr_pkg::*;
#(
  parameter int PAY_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_clk,
  input  logic             stb_rst,
  input  logic [PAY_W-1:0] pdata,
  input  logic             tx_dir,
  input  logic             clk_locked,
  input  logic [1:0]       ref_div_sel,
  input  logic             bit_en,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             overrun
);

  localparam int FRAME_W = PAY_W + 2;

  logic             active;
  logic [1:0]       div;
  logic [PAY_W-1:0] cap_word;
  logic             cap_tog;
  logic             step;
  logic             load;
  logic             hold_vld;
  logic [PAY_W-1:0] hold_word;

  assign active = tx_dir && clk_locked && (ref_div_sel != SFR_OFF);
  assign div    = sfr_div(ref_div_sel);

  sfr_strobe_capture #(.PAY_W(PAY_W)) u_capture (
    .stb_clk  (stb_clk),
    .stb_rst  (stb_rst),
    .pdata    (pdata),
    .cap_word (cap_word),
    .cap_tog  (cap_tog)
  );

  sfr_word_handoff #(.PAY_W(PAY_W), .SYNC_STAGES(SYNC_STAGES)) u_handoff (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .take      (load),
    .tog_in    (cap_tog),
    .word_in   (cap_word),
    .hold_vld  (hold_vld),
    .hold_word (hold_word),
    .ovf       (overrun)
  );

  sfr_bit_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .bit_en (bit_en),
    .div    (div),
    .step   (step),
    .load   (load)
  );

  sfr_frame_shifter #(.PAY_W(PAY_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .step      (step),
    .load      (load),
    .hold_vld  (hold_vld),
    .hold_word (hold_word),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat)
  );

  AST_OVERRUN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(active)); // R9

endmodule

// File: tb/strobe_serial_framer_tb.sv
`timescale 1ns/100ps
module strobe_serial_framer_tb;

  localparam int PAY_W   = 12;
  localparam int FRAME_W = PAY_W + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             stb_clk = 1'b0;
  logic             stb_rst = 1'b1;
  logic [PAY_W-1:0] pdata = '0;
  logic             tx_dir = 1'b0;
  logic             clk_locked = 1'b0;
  logic [1:0]       ref_div_sel = 2'b01;
  logic             bit_en = 1'b0;
  logic             ser_clk, ser_dat, overrun;

  strobe_serial_framer #(.PAY_W(PAY_W)) u_dut (
    .clk(clk), .rst(rst), .stb_clk(stb_clk), .stb_rst(stb_rst), .pdata(pdata),
    .tx_dir(tx_dir), .clk_locked(clk_locked), .ref_div_sel(ref_div_sel),
    .bit_en(bit_en), .ser_clk(ser_clk), .ser_dat(ser_dat), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- strobe source ----------------
  logic             stb_run = 1'b1;
  logic             accept  = 1'b0;
  int               stb_half = 35;
  int               edges = 0;
  int               last_pushed = -1;
  int               q[$];
  logic [PAY_W-1:0] seed = 12'h5a3;

  initial begin
    #1;
    forever begin
      if (stb_run) begin
        seed  = seed + 12'h2c9;
        pdata = seed;
        #(stb_half);
        stb_clk = 1'b1;
        if (!stb_rst) begin
          edges++;
          if (accept) begin
            q.push_back(int'(pdata));
            last_pushed = int'(pdata);
          end
        end
        #(stb_half);
        stb_clk = 1'b0;
      end else begin
        #1;
      end
    end
  end

  // ---------------- reference model ----------------
  int   pcnt = 0;
  int   slot = FRAME_W - 1;
  bit   exp_clk = 1'b0;
  bit   act_m = 1'b0;
  bit   new_slot = 1'b0;
  bit   after_fill_m = 1'b1;
  bit   relaxed = 1'b0;
  bit [FRAME_W-1:0] fbits;
  int   valid_frames = 0, fill_frames = 0, ovf_cnt = 0;
  int   gap_fill = 0, interior_fill = 0, rx_last = -1;
  int   en_gap = 1, en_cnt = 0;

  always @(posedge clk) begin
    act_m    = tx_dir && clk_locked && (ref_div_sel != 2'b00) && !rst;
    new_slot = 1'b0;
    if (!act_m) begin
      pcnt = 0; slot = FRAME_W - 1; exp_clk = 1'b0; after_fill_m = 1'b1;
    end else if (bit_en) begin
      if (pcnt == int'(ref_div_sel) - 1) begin
        pcnt     = 0;
        slot     = (slot + 1) % FRAME_W;
        exp_clk  = (slot % 2) == 0;
        new_slot = 1'b1;
      end else begin
        pcnt++;
      end
    end
  end

  task automatic check_frame();
    int pay;
    if (fbits == '0) begin
      fill_frames++;
      gap_fill++;
      after_fill_m = 1'b1;
    end else begin
      pay = int'(fbits[PAY_W-1:0]);
      chk(fbits[FRAME_W-1] == 1'b1, "R2", "valid flag", fbits[FRAME_W-1], 1);
      chk(fbits[FRAME_W-2] == after_fill_m, "R3", "start marker",
          fbits[FRAME_W-2], after_fill_m);
      if (relaxed)
        while (q.size() > 0 && q[0] != pay) void'(q.pop_front());
      if (q.size() == 0) chk(1'b0, "R5", "unexpected word", pay, -1);
      else begin
        chk(q[0] == pay, "R5", "payload order", pay, q[0]);
        void'(q.pop_front());
      end
      if (valid_frames > 0) interior_fill += gap_fill;
      gap_fill = 0;
      valid_frames++;
      rx_last = pay;
      after_fill_m = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (act_m) chk(ser_clk === exp_clk, "R1", "ser_clk phase", ser_clk, exp_clk);
      else begin
        chk(ser_clk === 1'b0, "R8", "ser_clk idle", ser_clk, 0);
        chk(ser_dat === 1'b0, "R8", "ser_dat idle", ser_dat, 0);
      end
      if (overrun === 1'b1) ovf_cnt++;
      if (new_slot) begin
        fbits[FRAME_W-1-slot] = ser_dat;
        if (slot == FRAME_W - 1) check_frame();
      end
    end
    en_cnt++;
    bit_en = (en_cnt % en_gap) == 0;
  end

  // ---------------- sequences ----------------
  task automatic idle_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_phase(input logic [1:0] sel, input int gap, input bit rel);
    @(negedge clk);
    tx_dir = 1'b0;
    idle_clks(4);
    ref_div_sel = sel; en_gap = gap; relaxed = rel;
    q.delete();
    valid_frames = 0; fill_frames = 0; ovf_cnt = 0;
    gap_fill = 0; interior_fill = 0; rx_last = -1;
    accept = 1'b1; clk_locked = 1'b1; tx_dir = 1'b1;
  endtask

  task automatic strobe_burst(input int half, input int n);
    int target;
    stb_half = half;
    target = edges + n;
    stb_run = 1'b1;
    wait (edges >= target);
    stb_run = 1'b0;
  endtask

  initial begin
    stb_run = 1'b1;
    idle_clks(12);
    // R10: reset state
    chk(ser_clk === 1'b0 && ser_dat === 1'b0, "R10", "outputs in reset", ser_dat, 0);
    chk(overrun === 1'b0, "R10", "overrun in reset", overrun, 0);
    stb_run = 1'b0;
    idle_clks(20);
    rst = 1'b0; stb_rst = 1'b0;
    @(negedge clk);
    chk(ser_clk === 1'b0 && ser_dat === 1'b0, "R10", "outputs after reset", ser_clk, 0);

    // R5 R4 R3: slow strobe, undivided
    start_phase(2'b01, 1, 1'b0);
    idle_clks(50);
    strobe_burst(100, 20);
    idle_clks(100);
    chk(q.size() == 0, "R5", "words left (slow)", q.size(), 0);
    chk(valid_frames == 20, "R5", "data frames (slow)", valid_frames, 20);
    chk(interior_fill > 0, "R4", "filler between words", interior_fill, 1);
    chk(ovf_cnt == 0, "R9", "no overrun (slow)", ovf_cnt, 0);

    // R6: strobe at exactly the frame rate
    start_phase(2'b01, 1, 1'b0);
    idle_clks(30);
    strobe_burst(35, 30);
    idle_clks(100);
    chk(q.size() == 0, "R5", "words left (equal)", q.size(), 0);
    chk(interior_fill == 0, "R6", "filler inside equal-rate burst", interior_fill, 0);
    chk(ovf_cnt == 0, "R9", "no overrun (equal)", ovf_cnt, 0);

    // R7: divide by two with sparse enable
    start_phase(2'b10, 2, 1'b0);
    idle_clks(60);
    strobe_burst(200, 12);
    idle_clks(300);
    chk(q.size() == 0, "R7", "words left (div2)", q.size(), 0);
    chk(valid_frames == 12, "R7", "data frames (div2)", valid_frames, 12);

    // R7: divide by three
    start_phase(2'b11, 1, 1'b0);
    idle_clks(60);
    strobe_burst(150, 12);
    idle_clks(200);
    chk(q.size() == 0, "R7", "words left (div3)", q.size(), 0);
    chk(valid_frames == 12, "R7", "data frames (div3)", valid_frames, 12);
    chk(ovf_cnt == 0, "R9", "no overrun (div3)", ovf_cnt, 0);

    // R9: strobe faster than the frame
    start_phase(2'b11, 1, 1'b1);
    idle_clks(60);
    strobe_burst(35, 20);
    idle_clks(200);
    chk(ovf_cnt > 0, "R9", "overrun seen", ovf_cnt, 1);
    chk(rx_last == last_pushed, "R9", "newest word kept", rx_last, last_pushed);

    // R8: each inactive condition, with words strobed meanwhile
    for (int v = 0; v < 3; v++) begin
      start_phase(2'b01, 1, 1'b0);
      accept = 1'b0;
      if (v == 0) tx_dir = 1'b0;
      else if (v == 1) clk_locked = 1'b0;
      else ref_div_sel = 2'b00;
      idle_clks(10);
      strobe_burst(35, 10);
      idle_clks(20);
      tx_dir = 1'b1; clk_locked = 1'b1; ref_div_sel = 2'b01; accept = 1'b1;
      idle_clks(100);
      chk(valid_frames == 0, "R8", "words from inactive time sent", valid_frames, 0);
      chk(fill_frames > 0, "R4", "filler after reactivation", fill_frames, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule